// File: doc/BRIEF.md
# Key Wakeup Interrupt Controller

This block watches eight key inputs that idle high and wake the system when a key is pressed. Each input first passes through a two-flop synchroniser. A per-input detector then notices a high-to-low transition, and a per-input latch records it. Only transitions and never levels set the latches. An 8-bit mask decides which inputs may set their latch at all.

Any newly latched input raises one shared flag. The interrupt line is the flag gated by a single global enable. Software clears the shared flag with a one-cycle clear pulse, and that pulse empties all eight latches in the same cycle. If a new transition is recognised in the cycle of the clear, the new event takes priority over the clear. The latch bank is visible on a read-only output for test.

Top module: `kwu_ctrl`

## Requirements
- R1: After reset all eight latches, the mask, the global enable and the shared flag are 0, and the interrupt output is low.
- R2: A pin that is first sampled low at clock edge n, after being high at edge n-1, sets its latch (bit i of `kw_latch` for pin i) at edge n+2 if mask bit i is 1 at that edge.
- R3: A pin held low does not set its latch again once the latch has been cleared.
- R4: A rising transition on a pin never sets its latch.
- R5: Transitions on a pin whose mask bit is 0 leave both its latch and the shared flag unchanged.
- R6: The shared flag is set in the same cycle as any latch is set, and it is 1 exactly when at least one latch is 1.
- R7: `kw_irq` is 1 exactly when the shared flag is 1 and the global enable is 1.
- R8: A clear pulse empties all eight latches and the shared flag at the next edge.
- R9: When a latch is set at the same edge as a clear, that latch and the flag stay set while the other latches are cleared.
- R10: A mask or global-enable write takes effect at the edge where its write strobe is high. The new value applies from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kw_pin | input | 8 | Key inputs, idle high, asynchronous |
| mask_we | input | 1 | Write strobe for the per-input mask |
| mask_wdata | input | 8 | New mask value, bit i enables pin i |
| gen_we | input | 1 | Write strobe for the global enable |
| gen_wdata | input | 1 | New global enable value |
| flag_clr | input | 1 | One-cycle pulse that clears the flag and all latches |
| kw_flag | output | 1 | Shared wakeup flag |
| kw_irq | output | 1 | Interrupt request |
| kw_latch | output | 8 | Per-input latch states |

## Verification
The bench holds a key low across a clear. A design that latched on level instead of on a transition would set the latch again at once. It also clears in exactly the cycle a new transition lands. A design that let the clear win would lose that key press, and one that ignored the clear would keep stale latches. Transitions are sent to masked inputs and with the global enable off. This catches designs that leak masked events into the flag or that drive the interrupt from the flag alone. Releases of keys are also checked, so that a detector sensitive to both directions is reported.

// File: rtl/kwu_pkg.sv
package kwu_pkg;
  localparam int unsigned KW_N = 8;

  // Next latch vector: clear wipes everything, fresh events always survive.
  function automatic logic [KW_N-1:0] latch_next(
    input logic [KW_N-1:0] cur,
    input logic [KW_N-1:0] ev,
    input logic            clr
  );
    return (clr ? '0 : cur) | ev;
  endfunction

  // Next shared flag, same priority rule.
  function automatic logic flag_next(
    input logic cur,
    input logic any_ev,
    input logic clr
  );
    return (cur & ~clr) | any_ev;
  endfunction
endpackage

// File: rtl/kwu_sync.sv
module kwu_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/kwu_fall_det.sv
module kwu_fall_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign fall[i] = prev_q[i] & ~lvl[i];
  end
endmodule

// File: rtl/kwu_latch_bank.sv
module kwu_latch_bank
  import kwu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KW_N-1:0] fall,
  input  logic [KW_N-1:0] mask,
  input  logic            clr,
  output logic [KW_N-1:0] set_vec,
  output logic [KW_N-1:0] latch_q,
  output logic            flag_q
);
  assign set_vec = fall & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      latch_q <= latch_next(latch_q, set_vec, clr);
      flag_q  <= flag_next(flag_q, |set_vec, clr);
    end
  end
endmodule

// File: rtl/kwu_ctrl.sv
module kwu_ctrl
  import kwu_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KW_N-1:0] kw_pin,
  input  logic            mask_we,
  input  logic [KW_N-1:0] mask_wdata,
  input  logic            gen_we,
  input  logic            gen_wdata,
  input  logic            flag_clr,
  output logic            kw_flag,
  output logic            kw_irq,
  output logic [KW_N-1:0] kw_latch
);
  logic [KW_N-1:0] mask_q;
  logic            gen_q;
  logic [KW_N-1:0] pin_sync;
  logic [KW_N-1:0] fall_vec;
  logic [KW_N-1:0] set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      gen_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      if (gen_we)  gen_q  <= gen_wdata;
    end
  end

  kwu_sync #(.W(KW_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(kw_pin), .q(pin_sync)
  );

  kwu_fall_det #(.W(KW_N)) u_fall (
    .clk(clk), .rst_n(rst_n), .lvl(pin_sync), .fall(fall_vec)
  );

  kwu_latch_bank u_bank (
    .clk(clk), .rst_n(rst_n), .fall(fall_vec), .mask(mask_q),
    .clr(flag_clr), .set_vec(set_vec), .latch_q(kw_latch), .flag_q(kw_flag)
  );

  assign kw_irq = kw_flag & gen_q;
endmodule

// File: rtl/kwu_ctrl_chk.sv
module kwu_ctrl_chk
  import kwu_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            flag_clr,
  input logic [KW_N-1:0] fall_vec,
  input logic [KW_N-1:0] set_vec,
  input logic [KW_N-1:0] mask_q,
  input logic            gen_q,
  input logic            kw_flag,
  input logic            kw_irq,
  input logic [KW_N-1:0] kw_latch
);
  assert_flag_matches_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kw_flag == (|kw_latch));

  assert_irq_gating_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kw_irq == (kw_flag && gen_q));

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && set_vec == '0) |=> (kw_latch == '0 && !kw_flag));

  assert_event_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> kw_flag);

  assert_masked_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((kw_latch & ~$past(kw_latch) & ~$past(mask_q)) == '0));

  assert_only_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((kw_latch & ~$past(kw_latch) & ~$past(fall_vec)) == '0));
endmodule

bind kwu_ctrl kwu_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .fall_vec(fall_vec),
  .set_vec(set_vec), .mask_q(mask_q), .gen_q(gen_q), .kw_flag(kw_flag),
  .kw_irq(kw_irq), .kw_latch(kw_latch)
);

// File: tb/kwu_ctrl_bench.sv
module kwu_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] kw_pin = 8'hFF;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wdata = 8'h00;
  logic       gen_we = 1'b0;
  logic       gen_wdata = 1'b0;
  logic       flag_clr = 1'b0;
  logic       kw_flag, kw_irq;
  logic [7:0] kw_latch;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  kwu_ctrl u_kwu_ctrl (
    .clk(clk), .rst_n(rst_n), .kw_pin(kw_pin), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .gen_we(gen_we), .gen_wdata(gen_wdata),
    .flag_clr(flag_clr), .kw_flag(kw_flag), .kw_irq(kw_irq), .kw_latch(kw_latch)
  );

  // Behavioural model: pin history queue, newest sample at index 0.
  logic [7:0] hist[$];
  logic [7:0] m_mask, m_lat;
  logic       m_gen, m_flag;

  always @(posedge clk) begin
    logic [7:0] ev;
    if (!rst_n) begin
      hist = {8'hFF, 8'hFF, 8'hFF, 8'hFF};
      m_mask = 0; m_gen = 0; m_lat = 0; m_flag = 0;
    end else begin
      hist.push_front(kw_pin);
      if (hist.size() > 6) void'(hist.pop_back());
      // transition seen: high three samples ago, low two samples ago
      ev = hist[3] & ~hist[2] & m_mask;
      if (flag_clr) begin m_lat = 0; m_flag = 0; end
      m_lat = m_lat | ev;
      if (ev != 0) m_flag = 1;
      if (mask_we) m_mask = mask_wdata;
      if (gen_we)  m_gen  = gen_wdata;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 latch vs model", kw_latch, m_lat);
      chk("R6 flag vs model", kw_flag, m_flag);
      chk("R7 irq vs model", kw_irq, m_flag & m_gen);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mask(input logic [7:0] v);
    mask_we = 1; mask_wdata = v; cyc(1); mask_we = 0;
  endtask

  task automatic wr_gen(input logic v);
    gen_we = 1; gen_wdata = v; cyc(1); gen_we = 0;
  endtask

  task automatic clear;
    flag_clr = 1; cyc(1); flag_clr = 0;
  endtask

  initial begin
    cyc(3);
    chk("R1 latch reset", kw_latch, 0);
    chk("R1 flag reset", kw_flag, 0);
    chk("R1 irq reset", kw_irq, 0);
    rst_n = 1;
    cyc(2);

    // R10: writes apply next cycle; masked-off default means no latching
    kw_pin = 8'hFE; cyc(5);
    chk("R5 default mask zero", kw_latch, 0);
    kw_pin = 8'hFF;
    wr_mask(8'hFF); wr_gen(1); cyc(4);

    // R2: pin 3 falls; visible three negedges later
    kw_pin = 8'hF7; cyc(2);
    chk("R2 not yet latched", kw_latch, 0);
    cyc(1);
    chk("R2 latch pin3", kw_latch, 8'h08);
    chk("R7 irq on", kw_irq, 1);

    // R3: hold low across clear
    clear(); cyc(5);
    chk("R3 no relatch on level", kw_latch, 0);
    chk("R8 flag cleared", kw_flag, 0);
    // R4: release
    kw_pin = 8'hFF; cyc(5);
    chk("R4 rising ignored", kw_latch, 0);

    // R5: mask off upper nibble, drop pin 6
    wr_mask(8'h0F);
    kw_pin = 8'hBF; cyc(5);
    chk("R5 masked latch", kw_latch, 0);
    chk("R5 masked flag", kw_flag, 0);
    kw_pin = 8'hFF; cyc(4);

    // R7: global disable with event
    wr_gen(0);
    kw_pin = 8'hFE; cyc(4);
    chk("R6 flag set", kw_flag, 1);
    chk("R7 irq gated", kw_irq, 0);
    kw_pin = 8'hFF;
    wr_gen(1); cyc(1);
    chk("R10 enable write", kw_irq, 1);

    // R9: pin 0 latched already; pin 2 falls with clear on its landing edge
    kw_pin = 8'hFB; cyc(2);
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R9 event beats clear", kw_latch, 8'h04);
    chk("R9 flag kept", kw_flag, 1);
    kw_pin = 8'hFF; cyc(4);
    clear(); cyc(1);
    chk("R8 all cleared", kw_latch, 0);

    // multi-pin pattern
    wr_mask(8'hA5);
    kw_pin = 8'h00; cyc(5);
    chk("R2 multi pattern", kw_latch, 8'hA5);
    kw_pin = 8'hFF; cyc(4);
    clear(); cyc(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule